// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This block sits in the clock controller and decides when the chip leaves run mode for wait or stop mode. Software programs a 2-bit target mode. After that, the processor core executes a wait-for-interrupt instruction, and the block then gates the clock groups that belong to the chosen mode. A wake event from the core brings the chip back to run and turns every gated clock on again.

Entry requires an "armed" flag, which only a write of wait or stop sets, together with a fresh rising edge of the core's idle level that arrives after that write. The core can go idle while the mode is still run and then wake from an interrupt that the interrupt controller never saw. If software then writes wait or stop while the core is still awake, that earlier idle period cannot cause an entry. Entry is also refused while the interrupt controller holds a pending unmasked interrupt.

Each clock group has a parameter mask that says whether wait gates it and whether stop gates it. The current mode is reported on a 2-bit status output that uses the same encoding as the mode write.

Top module: `lpm_entry_seq`

## Requirements
- R1: After reset, the status output reads 00 (run), all clock enables are 1 and the block is disarmed.
- R2: Mode code 00 means run, 01 means wait and 10 means stop. The status output reports the current state in this same encoding and never shows 11.
- R3: Entry takes place at the clock edge where a rising edge of core_idle is first sampled, and only if the armed flag was already set before that edge. A core_idle edge in the same cycle as a mode write does not cause entry. Neither does a core_idle level that stays high across the write.
- R4: Suppose a WFI occurs while the mode is run, the core then wakes, and wait or stop is written. The block stays in run until core_idle has gone low and risen again.
- R5: If irq_pending is high in the cycle where core_idle rises, entry is blocked.
- R6: A write of code 11 is handled as run. It disarms the block and does not allow a later entry.
- R7: In wait or stop, core_wake returns the state to run at the next clock edge, and all clock enables go back to 1 on that same edge.
- R8: In wait, clock enable bit g is 0 exactly when bit g of WAIT_GATE_MASK is 1. In stop, clock enable bit g is 0 exactly when bit g of STOP_GATE_MASK is 1.
- R9: A return to run clears the armed flag. A later idle edge with no new wait or stop write leaves the block in run.
- R10: A write of 00 disarms the block, so a following idle edge leaves it in run.
- R11: If core_wake is high in the cycle where core_idle rises, entry is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | One-cycle strobe that writes the target mode |
| mode_wdata | input | 2 | Mode code to write: 00 run, 01 wait, 10 stop, 11 treated as run |
| core_idle | input | 1 | High while the core is halted in wait-for-interrupt |
| core_wake | input | 1 | Wake event from the core |
| irq_pending | input | 1 | A pending, unmasked interrupt is present at the interrupt controller |
| lp_state | output | 2 | Current mode, in the same encoding as the mode write |
| clk_en | output | NUM_GATES | Enable for each clock group; 1 means the clock runs |

## Verification
The hardest case to reach from the ports is a stale idle indication. The core has to go idle while the mode is run and wake without the interrupt controller taking part, and only then may wait or stop be written. The bench plays exactly that order. It raises core_idle under mode 00, pulses the wake input, and writes the new mode in two variants: one with core_idle still held high and one after it has dropped. It then checks that only the variant that sees a fresh rising edge enters. A sweep covers every mode code against each combination of interrupt and wake at the idle edge. It also writes the mode in the same cycle as the idle edge, and re-arms the block after a wake to confirm that the armed flag was cleared.

// File: rtl/lpm_entry_seq.sv
module lpm_entry_seq #(
  parameter int          NUM_GATES       = 8,
  parameter logic [7:0]  WAIT_GATE_MASK  = 8'h0F,
  parameter logic [7:0]  STOP_GATE_MASK  = 8'hFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_wr,
  input  logic [1:0]           mode_wdata,
  input  logic                 core_idle,
  input  logic                 core_wake,
  input  logic                 irq_pending,
  output logic [1:0]           lp_state,
  output logic [NUM_GATES-1:0] clk_en
);

  localparam logic [1:0] RUN  = 2'b00;
  localparam logic [1:0] WAIT = 2'b01;
  localparam logic [1:0] STOP = 2'b10;

  logic [1:0] mode_q;
  logic [1:0] state_q;
  logic       armed_q;
  logic       idle_q;

  wire wr_lp     = mode_wr && (mode_wdata == WAIT || mode_wdata == STOP);
  wire idle_rise = core_idle && !idle_q;
  wire in_lp     = state_q != RUN;
  wire leave_lp  = in_lp && core_wake;
  wire enter_lp  = !in_lp && armed_q && idle_rise && !mode_wr &&
                   !irq_pending && !core_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= 1'b0;
    else        idle_q <= core_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= RUN;
    else if (mode_wr) mode_q <= (mode_wdata == 2'b11) ? RUN : mode_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (leave_lp) armed_q <= 1'b0;
    else if (mode_wr)  armed_q <= wr_lp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= RUN;
    else if (enter_lp) state_q <= mode_q;
    else if (leave_lp) state_q <= RUN;
  end

  assign lp_state = state_q;

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    assign clk_en[g] = !((state_q == WAIT && WAIT_GATE_MASK[g]) ||
                         (state_q == STOP && STOP_GATE_MASK[g]));
  end

  a_r2_no_reserved_state: assert property (@(posedge clk) disable iff (!rst_n)
    lp_state != 2'b11);

  a_r3_entry_needs_fresh_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_state == RUN && !(armed_q && core_idle && !idle_q)) |=> lp_state == RUN);

  a_r5_irq_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_state == RUN && irq_pending) |=> lp_state == RUN);

  a_r11_wake_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_state == RUN && core_wake) |=> lp_state == RUN);

  a_r7_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_state != RUN && core_wake) |=> (lp_state == RUN && &clk_en));

  a_r9_disarm_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_state != RUN && core_wake && !mode_wr) |=> !armed_q);

  a_r6_target_matches_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_state == RUN && $past(lp_state) == RUN && !mode_wr) |=> (lp_state == RUN || lp_state == mode_q));

endmodule

// File: tb/lpm_entry_seq_tb.sv
module lpm_entry_seq_tb;
  localparam int         NG = 8;
  localparam logic [7:0] WM = 8'h0F;
  localparam logic [7:0] SM = 8'hFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic core_idle = 1'b0;
  logic core_wake = 1'b0;
  logic irq_pending = 1'b0;
  logic [1:0] lp_state;
  logic [NG-1:0] clk_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpm_entry_seq #(.NUM_GATES(NG), .WAIT_GATE_MASK(WM), .STOP_GATE_MASK(SM)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .core_idle(core_idle), .core_wake(core_wake), .irq_pending(irq_pending),
    .lp_state(lp_state), .clk_en(clk_en));

  function automatic logic [NG-1:0] exp_en(input logic [1:0] s);
    if (s == 2'b01) return ~WM;
    if (s == 2'b10) return ~SM;
    return '1;
  endfunction

  task automatic chk(input string req, input logic [1:0] es);
    n_chk++;
    if (lp_state !== es || clk_en !== exp_en(es)) begin
      n_bad++;
      $display("FAIL %s: state=%b en=%h expected state=%b en=%h",
               req, lp_state, clk_en, es, exp_en(es));
    end
  endtask

  task automatic write_mode(input logic [1:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic idle_edge(input logic irq, input logic wk);
    @(negedge clk); core_idle = 1'b1; irq_pending = irq; core_wake = wk;
    @(negedge clk); irq_pending = 1'b0; core_wake = 1'b0;
  endtask

  task automatic wake_up();
    @(negedge clk); core_idle = 1'b0; core_wake = 1'b1;
    @(negedge clk); core_wake = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: state=%b expected run completion", lp_state);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 2'b00);
    rst_n = 1'b1;
    idle_edge(1'b0, 1'b0);
    chk("R1 disarmed after reset", 2'b00);
    @(negedge clk); core_idle = 1'b0;

    // R2 R5 R6 R8 R10 R11 sweep over mode code, irq and wake
    for (int m = 0; m < 4; m++)
      for (int irq = 0; irq < 2; irq++)
        for (int wk = 0; wk < 2; wk++) begin
          logic [1:0] es;
          write_mode(2'(m));
          idle_edge(1'(irq), 1'(wk));
          es = ((m == 1 || m == 2) && irq == 0 && wk == 0) ? 2'(m) : 2'b00;
          chk("R2 R5 R6 R8 R10 R11 sweep", es);
          wake_up();
          chk("R7 wake to run", 2'b00);
        end

    // R9: after a return to run, a new idle edge without a rewrite stays in run
    write_mode(2'b10);
    idle_edge(1'b0, 1'b0);
    chk("R8 stop entry", 2'b10);
    wake_up();
    chk("R7 exit stop", 2'b00);
    idle_edge(1'b0, 1'b0);
    chk("R9 no re-entry without rewrite", 2'b00);
    @(negedge clk); core_idle = 1'b0;

    // R4 stale WFI: idle under run, wake, write wait while still idle
    write_mode(2'b00);
    idle_edge(1'b0, 1'b0);
    chk("R4 idle under run", 2'b00);
    @(negedge clk); core_wake = 1'b1;
    @(negedge clk); core_wake = 1'b0;
    write_mode(2'b01);
    repeat (3) @(negedge clk);
    chk("R4 stale idle does not enter", 2'b00);
    @(negedge clk); core_idle = 1'b0;
    idle_edge(1'b0, 1'b0);
    chk("R4 fresh idle enters wait", 2'b01);
    wake_up();

    // R3: write in the same cycle as the idle edge
    write_mode(2'b00);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = 2'b10; core_idle = 1'b1;
    @(negedge clk); mode_wr = 1'b0;
    chk("R3 same-cycle write no entry", 2'b00);
    repeat (2) @(negedge clk);
    chk("R3 held idle no entry", 2'b00);
    @(negedge clk); core_idle = 1'b0;
    idle_edge(1'b0, 1'b0);
    chk("R3 later fresh edge enters stop", 2'b10);
    @(negedge clk);
    chk("R3 stays in stop", 2'b10);
    wake_up();
    chk("R7 final exit", 2'b00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule